// File: doc/BRIEF.md
# Low-Side Channel Drive Sequencer

This block decides, one clock at a time, whether the gate of one low-side power switch may be driven. It takes a command from two sources, a pin-level input and a bit held by a serial register elsewhere on the chip. It merges them in one of four ways and then applies the protection rules on top of the merged command.

A thermal comparator ends conduction at once. It either lets the channel come back when it cools or keeps it off until the command is re-issued. A current-limit comparator is timed in microsecond ticks. In one mode it only raises a report after a filter window. In the other it latches the channel off after a shorter switch-off window. The mode may be changed while the timer is running.

The outputs are the gate enable, a request to the analog stage to regulate current, two event flags for the diagnosis logic and the slew-rate select bit passed to the driver.

Top module: `chan_drive_seq`

## Requirements
- R1: While rst_n is low and on the first cycle after it, gate_en, limit_req, ot_flag and ovl_flag are all 0.
- R2: The merged command is chosen by src_mode: 2'b00 uses par_in alone, 2'b01 uses par_in OR ser_bit, 2'b10 uses par_in AND ser_bit, 2'b11 uses ser_bit alone. With no fault, gate_en equals the merged command sampled at the previous clock edge.
- R3: When ot_hot is 1 while the channel conducts, gate_en is 0 in the same cycle. ot_flag is 1 from the next edge on.
- R4: With ot_latch = 0 (autorestart), once ot_hot returns to 0 and the command is still 1, gate_en returns to 1 and ot_flag to 0 one edge later.
- R5: With ot_latch = 1, the channel stays off after ot_hot clears. It conducts again one edge after a 0-to-1 transition of the merged command.
- R6: ot_hot has no effect while the channel is off: ot_flag stays 0.
- R7: With lim_mode = 0, ilim_hit held while conducting for SHUTOFF_TICKS tick pulses switches the channel off at the following edge and sets ovl_flag. Only a 0-to-1 command transition restores conduction and clears the flag.
- R8: With lim_mode = 1 the channel is never switched off by overload. limit_req is 1 whenever gate_en is 1. ovl_flag rises one edge after FILTER_TICKS tick pulses of continuous ilim_hit and drops one edge after ilim_hit ends.
- R9: A change of lim_mode while ilim_hit persists keeps the accumulated tick count. Switching to lim_mode = 0 after at least SHUTOFF_TICKS ticks switches off at the next edge.
- R10: The tick count restarts whenever ilim_hit drops. Cycles without a tick add nothing, so short or tickless overloads have no effect.
- R11: sleep = 1 forces gate_en to 0 from the next edge, whatever the command.
- R12: slew_sel always equals slew_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| par_in | input | 1 | pin-level command |
| ser_bit | input | 1 | serial-register command bit |
| src_mode | input | 2 | command merge select |
| sleep | input | 1 | low-power mode, forces off |
| ot_latch | input | 1 | 1 = latch off on overtemperature |
| lim_mode | input | 1 | 1 = limit and report, 0 = timed switch-off |
| slew_in | input | 1 | slew-rate select from configuration |
| tick | input | 1 | one-cycle microsecond pulse |
| ot_hot | input | 1 | channel thermal comparator |
| ilim_hit | input | 1 | current-limit comparator |
| gate_en | output | 1 | gate drive enable |
| limit_req | output | 1 | request to regulate current |
| ot_flag | output | 1 | channel off for overtemperature |
| ovl_flag | output | 1 | overload event |
| slew_sel | output | 1 | slew-rate select to driver |

## Verification
The checker assumes that every input is synchronous to clk and free of glitches, that tick is at most one cycle wide, and that configuration changes arrive as ordinary clocked levels. The bench drives all inputs just after the falling edge, so each one is stable across the next rising edge, and it holds tick high for whole stretches to make tick counts equal edge counts. The thermal and current comparators are only raised after the channel is known to conduct, except where the point is to show that they are ignored while it is off.

// File: rtl/chdrv_pkg.sv
package chdrv_pkg;
  typedef enum logic [1:0] {
    SRC_PAR = 2'b00,
    SRC_OR  = 2'b01,
    SRC_AND = 2'b10,
    SRC_SER = 2'b11
  } src_mode_e;
endpackage

// File: rtl/chdrv_cmd_sel.sv
module chdrv_cmd_sel
  import chdrv_pkg::*;
(
  input  logic       par_in,
  input  logic       ser_bit,
  input  logic [1:0] mode,
  output logic       cmd
);
  src_mode_e m;
  assign m = src_mode_e'(mode);

  always_comb begin
    unique case (m)
      SRC_PAR: cmd = par_in;
      SRC_OR:  cmd = par_in | ser_bit;
      SRC_AND: cmd = par_in & ser_bit;
      default: cmd = ser_bit;
    endcase
  end
endmodule

// File: rtl/chdrv_ovl_timer.sv
module chdrv_ovl_timer #(
  parameter int SHUTOFF_TICKS = 50,
  parameter int FILTER_TICKS  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic lim_mode,
  output logic shut_hit,
  output logic filt_hit
);
  localparam int CNT_MAX = (SHUTOFF_TICKS > FILTER_TICKS) ? SHUTOFF_TICKS : FILTER_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] MAX_L  = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] SHUT_L = CNT_W'(SHUTOFF_TICKS);
  localparam logic [CNT_W-1:0] FILT_L = CNT_W'(FILTER_TICKS);

  logic [CNT_W-1:0] cnt_q;

  // count survives lim_mode changes; only a drop of run restarts it
  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (!run)                    cnt_q <= '0;
    else if (tick && cnt_q != MAX_L)  cnt_q <= cnt_q + 1'b1;
  end

  assign shut_hit = run && !lim_mode && (cnt_q >= SHUT_L);
  assign filt_hit = run &&  lim_mode && (cnt_q >= FILT_L);
endmodule

// File: rtl/chdrv_ot_guard.sv
module chdrv_ot_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  input  logic on_q,
  input  logic latch_mode,
  input  logic rise,
  output logic off_next,
  output logic off_q
);
  always_comb begin
    off_next = off_q;
    if (hot && on_q)
      off_next = 1'b1;
    else if (off_q && (latch_mode ? rise : !hot))
      off_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) off_q <= 1'b0;
    else        off_q <= off_next;
  end
endmodule

// File: rtl/chan_drive_seq.sv
module chan_drive_seq #(
  parameter int SHUTOFF_TICKS = 50,
  parameter int FILTER_TICKS  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       par_in,
  input  logic       ser_bit,
  input  logic [1:0] src_mode,
  input  logic       sleep,
  input  logic       ot_latch,
  input  logic       lim_mode,
  input  logic       slew_in,
  input  logic       tick,
  input  logic       ot_hot,
  input  logic       ilim_hit,
  output logic       gate_en,
  output logic       limit_req,
  output logic       ot_flag,
  output logic       ovl_flag,
  output logic       slew_sel
);
  logic cmd, cmd_q, rise;
  logic gate_q, gate_n;
  logic ot_off_n, ot_off_q;
  logic ovl_off_q, ovl_off_n;
  logic shut_hit, filt_hit, filt_q;

  chdrv_cmd_sel u_sel (
    .par_in (par_in),
    .ser_bit(ser_bit),
    .mode   (src_mode),
    .cmd    (cmd)
  );

  assign rise = cmd && !cmd_q;

  chdrv_ot_guard u_ot (
    .clk       (clk),
    .rst_n     (rst_n),
    .hot       (ot_hot),
    .on_q      (gate_q),
    .latch_mode(ot_latch),
    .rise      (rise),
    .off_next  (ot_off_n),
    .off_q     (ot_off_q)
  );

  chdrv_ovl_timer #(
    .SHUTOFF_TICKS(SHUTOFF_TICKS),
    .FILTER_TICKS (FILTER_TICKS)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ilim_hit && gate_q),
    .tick    (tick),
    .lim_mode(lim_mode),
    .shut_hit(shut_hit),
    .filt_hit(filt_hit)
  );

  // timed switch-off latch, released only by a fresh command edge
  always_comb begin
    ovl_off_n = ovl_off_q;
    if (shut_hit)  ovl_off_n = 1'b1;
    else if (rise) ovl_off_n = 1'b0;
  end

  assign gate_n = cmd && !ot_off_n && !ovl_off_n && !sleep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= 1'b0;
      gate_q    <= 1'b0;
      ovl_off_q <= 1'b0;
      filt_q    <= 1'b0;
    end else begin
      cmd_q     <= cmd;
      gate_q    <= gate_n;
      ovl_off_q <= ovl_off_n;
      filt_q    <= filt_hit;
    end
  end

  // thermal trip cuts the gate without waiting for an edge
  assign gate_en   = gate_q && !ot_hot;
  assign limit_req = gate_en && lim_mode;
  assign ot_flag   = ot_off_q;
  assign ovl_flag  = ovl_off_q || filt_q;
  assign slew_sel  = slew_in;
endmodule

// File: rtl/chan_drive_seq_chk.sv
module chan_drive_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       par_in,
  input logic       ser_bit,
  input logic [1:0] src_mode,
  input logic       sleep,
  input logic       lim_mode,
  input logic       gate_en,
  input logic       limit_req,
  input logic       ot_flag,
  input logic       ovl_flag
);
  // R2
  par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == 2'b00 && !par_in) |=> !gate_en);

  // R2
  and_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == 2'b10 && !ser_bit) |=> !gate_en);

  // R3
  ot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |-> !gate_en);

  // R11
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !gate_en);

  // R8
  limit_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit_req |-> (lim_mode && !ot_flag));

  // R7
  shutoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovl_flag) && !$past(lim_mode)) |-> !gate_en);
endmodule

bind chan_drive_seq chan_drive_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .par_in   (par_in),
  .ser_bit  (ser_bit),
  .src_mode (src_mode),
  .sleep    (sleep),
  .lim_mode (lim_mode),
  .gate_en  (gate_en),
  .limit_req(limit_req),
  .ot_flag  (ot_flag),
  .ovl_flag (ovl_flag)
);

// File: tb/chan_drive_seq_tb.sv
module chan_drive_seq_tb;
  localparam int SHUT = 3;
  localparam int FILT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_in = 0, ser_bit = 0, sleep = 0, ot_latch = 0, lim_mode = 0;
  logic slew_in = 0, tick = 0, ot_hot = 0, ilim_hit = 0;
  logic [1:0] src_mode = 2'b00;
  logic gate_en, limit_req, ot_flag, ovl_flag, slew_sel;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  chan_drive_seq #(.SHUTOFF_TICKS(SHUT), .FILTER_TICKS(FILT)) u_dut (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_bit(ser_bit),
    .src_mode(src_mode), .sleep(sleep), .ot_latch(ot_latch),
    .lim_mode(lim_mode), .slew_in(slew_in), .tick(tick), .ot_hot(ot_hot),
    .ilim_hit(ilim_hit), .gate_en(gate_en), .limit_req(limit_req),
    .ot_flag(ot_flag), .ovl_flag(ovl_flag), .slew_sel(slew_sel)
  );

  // {src_mode, par_in, ser_bit, expected gate_en}
  localparam logic [4:0] VEC [16] = '{
    5'b00_00_0, 5'b00_01_0, 5'b00_10_1, 5'b00_11_1,
    5'b01_00_0, 5'b01_01_1, 5'b01_10_1, 5'b01_11_1,
    5'b10_00_0, 5'b10_01_0, 5'b10_10_0, 5'b10_11_1,
    5'b11_00_0, 5'b11_01_1, 5'b11_10_0, 5'b11_11_1
  };

  task automatic chk(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm();
    ilim_hit = 0; par_in = 0; cyc(1);
    par_in = 1; cyc(1);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk(gate_en, 0, "R1 gate in reset");
    chk(ot_flag | ovl_flag | limit_req, 0, "R1 flags in reset");
    rst_n = 1; cyc(1);
    chk(gate_en, 0, "R1 gate after reset");
    chk(ot_flag | ovl_flag, 0, "R1 flags after reset");

    // R2 merge table
    for (int i = 0; i < 16; i++) begin
      {src_mode, par_in, ser_bit} = VEC[i][4:1];
      cyc(1);
      chk(gate_en, VEC[i][0], $sformatf("R2 vector %0d", i));
    end

    // R3 / R4 autorestart
    src_mode = 2'b00; par_in = 1; ser_bit = 0; cyc(1);
    ot_hot = 1; #1;
    chk(gate_en, 0, "R3 same-cycle cut");
    cyc(1);
    chk(ot_flag, 1, "R3 flag set");
    ot_hot = 0; cyc(1);
    chk(gate_en, 1, "R4 restart");
    chk(ot_flag, 0, "R4 flag cleared");

    // R5 latch mode
    ot_latch = 1; ot_hot = 1; cyc(1);
    ot_hot = 0; cyc(2);
    chk(gate_en, 0, "R5 stays off");
    chk(ot_flag, 1, "R5 flag held");
    par_in = 0; cyc(1);
    chk(gate_en, 0, "R5 off with command low");
    par_in = 1; cyc(1);
    chk(gate_en, 1, "R5 rising command restores");
    chk(ot_flag, 0, "R5 flag released");
    ot_latch = 0;

    // R6 sensor ignored while off
    par_in = 0; cyc(1);
    ot_hot = 1; cyc(3);
    chk(ot_flag, 0, "R6 no flag while off");
    ot_hot = 0; par_in = 1; cyc(1);
    chk(gate_en, 1, "R6 turns on normally");

    // R7 timed switch-off
    lim_mode = 0; tick = 1; ilim_hit = 1; cyc(SHUT);
    chk(gate_en, 1, "R7 not before delay");
    cyc(1);
    chk(gate_en, 0, "R7 switched off");
    chk(ovl_flag, 1, "R7 flag");
    ilim_hit = 0; cyc(1);
    chk(gate_en, 0, "R7 stays latched");
    rearm();
    chk(gate_en, 1, "R7 rearmed by edge");
    chk(ovl_flag, 0, "R7 flag cleared");

    // R8 limit and report
    lim_mode = 1; #1;
    chk(limit_req, 1, "R8 limit request");
    ilim_hit = 1; cyc(FILT);
    chk(ovl_flag, 0, "R8 before filter");
    cyc(1);
    chk(ovl_flag, 1, "R8 reported");
    chk(gate_en, 1, "R8 keeps conducting");
    ilim_hit = 0; cyc(1);
    chk(ovl_flag, 0, "R8 report drops");

    // R9 mode change keeps count
    ilim_hit = 1; cyc(SHUT + 1);
    chk(gate_en, 1, "R9 on in mode 1");
    lim_mode = 0; cyc(1);
    chk(gate_en, 0, "R9 switch-off after mode change");
    rearm();

    // R10 no ticks, short bursts
    tick = 0; ilim_hit = 1; cyc(8);
    chk(gate_en, 1, "R10 no tick no count");
    ilim_hit = 0; tick = 1; cyc(1);
    ilim_hit = 1; cyc(SHUT - 1);
    ilim_hit = 0; cyc(1);
    ilim_hit = 1; cyc(SHUT - 1);
    ilim_hit = 0; cyc(1);
    chk(gate_en, 1, "R10 bursts restart count");
    chk(ovl_flag, 0, "R10 no flag");

    // R11 sleep
    sleep = 1; cyc(1);
    chk(gate_en, 0, "R11 sleep off");
    sleep = 0; cyc(1);
    chk(gate_en, 1, "R11 wake on");

    // R12 slew
    slew_in = 1; #1;
    chk(slew_sel, 1, "R12 slew high");
    slew_in = 0; #1;
    chk(slew_sel, 0, "R12 slew low");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule